// File: doc/BRIEF.md
# External Memory Byte Transfer Unit

This unit executes the byte-move instructions of an 8-bit controller core that shift one byte between a working register and external memory. Memory here means either the program space or the data space, and the byte can move in either direction. The fetch stage hands the unit the opcode, a working-register number, a register-pair number and up to two extension bytes, all in one `start` cycle. The unit then reads the pair's two registers through a register-file read port and forms a 16-bit effective address. It runs a request/ready handshake toward the selected memory space. At the end it writes the fetched byte into the working register (loads), or it has already placed the register's byte in memory (stores).

The address comes from one of four forms: the register pair alone, the pair plus a sign-extended one-byte index, the pair plus a two-byte index, or a two-byte direct address. The direct form reuses pair code 0 or 1 of the long-index opcodes. Bit 0 of the pair field picks the space: 0 selects program memory and 1 selects data memory. Completion is signalled after a fixed, opcode-dependent number of cycles, or later if memory is slow. No condition flags are touched, and the source byte is never modified.

Top module: `memxfer_unit`

## Requirements
- R1: Opcodes 0xC3 (load) and 0xD3 (store) address memory at {R[p&~1], R[p|1]}, where p is `pair_sel`, the even register is the high byte, and the odd register is the low byte. With ready given at the first request cycle, `done` is high in cycle 10, counting the cycle after the accepting edge as cycle 1.
- R2: Opcodes 0xE7 (load) and 0xF7 (store) address base + sign-extended `ext_lo`, modulo 2^16. With a prompt ready, `done` falls in cycle 12.
- R3: Opcodes 0xA7 (load) and 0xB7 (store) with `pair_sel[3:1]` nonzero address base + {`ext_hi`,`ext_lo`}, modulo 2^16. With a prompt ready, `done` falls in cycle 14.
- R4: Opcodes 0xA7/0xB7 with `pair_sel` equal to 0 or 1 use {`ext_hi`,`ext_lo`} directly as the address, with the same cycle count as R3.
- R5: `pair_sel[0]`=0 raises only `pmem_req` and `pair_sel[0]`=1 raises only `dmem_req`; the two are never high together.
- R6: A load drives `rf_we` for exactly one cycle, the `done` cycle, writing the memory byte to register `reg_sel`. A store drives `mem_we` with `mem_wdata` = R[`reg_sel`] during the request and never asserts `rf_we`.
- R7: The request first rises in cycle 4. It stays high, with `mem_addr` and `mem_we` unchanged, up to and including the cycle in which `mem_ready` is sampled high, and then drops.
- R8: `done` is a single-cycle pulse in cycle max(N, k+1), where N is the opcode's count and k is the ready cycle. `busy` is high from cycle 1 through the `done` cycle and low afterwards.
- R9: A `start` with any other opcode raises `illegal` in cycle 1 only, with no request, no register write and `busy` staying low.
- R10: A `start` while `busy` is high is ignored; the running transfer completes unchanged.
- R11: During and right after reset, `busy`, `done`, `illegal`, `rf_we`, `mem_we` and both requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Instruction bytes valid this cycle |
| opcode | input | 8 | Opcode byte |
| reg_sel | input | 4 | Working register number |
| pair_sel | input | 4 | Register-pair number or direct-mode marker |
| ext_hi | input | 8 | High extension byte (long index or direct address) |
| ext_lo | input | 8 | Low extension byte or short index |
| rf_raddr | output | 4 | Register-file read address |
| rf_rdata | input | 8 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write address |
| rf_wdata | output | 8 | Register-file write data |
| pmem_req | output | 1 | Program memory request |
| dmem_req | output | 1 | Data memory request |
| mem_addr | output | 16 | Shared memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with ready |
| mem_ready | input | 1 | Memory handshake completion |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer completes this cycle |
| illegal | output | 1 | Rejected opcode pulse |

## Verification
A wrong sequencer state shows up at the ports within a cycle or two. A request that starts early or late misses cycle 4, and a request that is not held drops before ready. A lost count moves `done` off its cycle or produces a second pulse. An address-formation fault is visible on `mem_addr` during the first request cycle. A wrong space bit is visible as the wrong request line. A wrongly captured register byte surfaces as a wrong write value at the end of the same instruction, or as a wrong read-back on a later load from the same address.

// File: rtl/memxfer_pkg.sv
package memxfer_pkg;
  localparam int MX_AW = 16;
  localparam int MX_DW = 8;
  localparam int MX_RW = 4;

  typedef enum logic [1:0] {AM_IND, AM_SHORT, AM_LONG, AM_DIRECT} amode_e;

  typedef struct packed {
    logic   legal;
    logic   store;
    amode_e mode;
    logic   dspace;
  } dec_t;

  typedef enum logic [2:0] {ST_IDLE, ST_RHI, ST_RLO, ST_RSRC, ST_ACC, ST_FIN} st_e;

  function automatic logic [MX_AW-1:0] sext_idx(input logic [MX_DW-1:0] v);
    return {{(MX_AW-MX_DW){v[MX_DW-1]}}, v};
  endfunction

  function automatic logic [MX_AW-1:0] ea_calc(input amode_e m,
                                               input logic [MX_AW-1:0] base,
                                               input logic [MX_DW-1:0] hi,
                                               input logic [MX_DW-1:0] lo);
    logic [MX_AW-1:0] r;
    case (m)
      AM_IND:    r = base;
      AM_SHORT:  r = base + sext_idx(lo);
      AM_LONG:   r = base + {hi, lo};
      default:   r = {hi, lo};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/memxfer_decode.sv
module memxfer_decode
  import memxfer_pkg::*;
(
  input  logic [7:0]       opcode,
  input  logic [MX_RW-1:0] pair_sel,
  output dec_t             dec
);
  logic direct_code;
  assign direct_code = (pair_sel[MX_RW-1:1] == '0);

  always_comb begin
    dec        = '0;
    dec.dspace = pair_sel[0];
    dec.mode   = AM_IND;
    case (opcode)
      8'hC3: begin dec.legal = 1'b1; dec.store = 1'b0; dec.mode = AM_IND;   end
      8'hD3: begin dec.legal = 1'b1; dec.store = 1'b1; dec.mode = AM_IND;   end
      8'hE7: begin dec.legal = 1'b1; dec.store = 1'b0; dec.mode = AM_SHORT; end
      8'hF7: begin dec.legal = 1'b1; dec.store = 1'b1; dec.mode = AM_SHORT; end
      8'hA7: begin
        dec.legal = 1'b1; dec.store = 1'b0;
        dec.mode  = direct_code ? AM_DIRECT : AM_LONG;
      end
      8'hB7: begin
        dec.legal = 1'b1; dec.store = 1'b1;
        dec.mode  = direct_code ? AM_DIRECT : AM_LONG;
      end
      default: dec.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/memxfer_agen.sv
module memxfer_agen
  import memxfer_pkg::*;
(
  input  amode_e           mode,
  input  logic [MX_DW-1:0] base_hi,
  input  logic [MX_DW-1:0] base_lo,
  input  logic [MX_DW-1:0] ext_hi,
  input  logic [MX_DW-1:0] ext_lo,
  output logic [MX_AW-1:0] addr
);
  assign addr = ea_calc(mode, {base_hi, base_lo}, ext_hi, ext_lo);
endmodule

// File: rtl/memxfer_seq.sv
module memxfer_seq
  import memxfer_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_accept,
  input  logic             mem_ready,
  input  logic [CNT_W-1:0] ncyc,
  output st_e              st,
  output logic [CNT_W-1:0] cnt,
  output logic             done,
  output logic             busy
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  assign busy = (st != ST_IDLE);
  assign done = (st == ST_FIN) && (cnt >= ncyc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start_accept) st <= ST_RHI;
        ST_RHI:  st <= ST_RLO;
        ST_RLO:  st <= ST_RSRC;
        ST_RSRC: st <= ST_ACC;
        ST_ACC:  if (mem_ready) st <= ST_FIN;
        ST_FIN:  if (done) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
      if (st == ST_IDLE) begin
        if (start_accept) cnt <= CNT_ONE;
      end else if (done) begin
        cnt <= '0;
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + CNT_ONE;
      end
    end
  end
endmodule

// File: rtl/memxfer_unit.sv
module memxfer_unit
  import memxfer_pkg::*;
#(
  parameter int CYC_IND   = 10,
  parameter int CYC_SHORT = 12,
  parameter int CYC_LONG  = 14,
  parameter int CNT_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       opcode,
  input  logic [MX_RW-1:0] reg_sel,
  input  logic [MX_RW-1:0] pair_sel,
  input  logic [MX_DW-1:0] ext_hi,
  input  logic [MX_DW-1:0] ext_lo,
  output logic [MX_RW-1:0] rf_raddr,
  input  logic [MX_DW-1:0] rf_rdata,
  output logic             rf_we,
  output logic [MX_RW-1:0] rf_waddr,
  output logic [MX_DW-1:0] rf_wdata,
  output logic             pmem_req,
  output logic             dmem_req,
  output logic [MX_AW-1:0] mem_addr,
  output logic             mem_we,
  output logic [MX_DW-1:0] mem_wdata,
  input  logic [MX_DW-1:0] mem_rdata,
  input  logic             mem_ready,
  output logic             busy,
  output logic             done,
  output logic             illegal
);
  localparam logic [CNT_W-1:0] N_IND   = CNT_W'(CYC_IND);
  localparam logic [CNT_W-1:0] N_SHORT = CNT_W'(CYC_SHORT);
  localparam logic [CNT_W-1:0] N_LONG  = CNT_W'(CYC_LONG);

  dec_t dec_in, dec_q;
  logic [MX_RW-1:0] reg_q;
  logic [MX_RW-2:0] pair_q;
  logic [MX_DW-1:0] hi_q, lo_q, base_hi, base_lo, src_q, xfer_q;
  logic [CNT_W-1:0] ncyc, cyc_cnt;
  logic             illegal_q;
  st_e              st;

  // named internal events, observed by the checker
  logic start_accept, start_reject, req_active, access_fire;

  memxfer_decode u_dec (.opcode(opcode), .pair_sel(pair_sel), .dec(dec_in));

  assign start_accept = start && !busy && dec_in.legal;
  assign start_reject = start && !busy && !dec_in.legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q     <= '0;
      reg_q     <= '0;
      pair_q    <= '0;
      hi_q      <= '0;
      lo_q      <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= start_reject;
      if (start_accept) begin
        dec_q  <= dec_in;
        reg_q  <= reg_sel;
        pair_q <= pair_sel[MX_RW-1:1];
        hi_q   <= ext_hi;
        lo_q   <= ext_lo;
      end
    end
  end

  always_comb begin
    case (dec_q.mode)
      AM_IND:   ncyc = N_IND;
      AM_SHORT: ncyc = N_SHORT;
      default:  ncyc = N_LONG;
    endcase
  end

  memxfer_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_accept(start_accept), .mem_ready(mem_ready),
    .ncyc(ncyc), .st(st), .cnt(cyc_cnt), .done(done), .busy(busy)
  );

  // register-file read sequencing: even (high) half, odd (low) half, then source
  always_comb begin
    case (st)
      ST_RHI:  rf_raddr = {pair_q, 1'b0};
      ST_RLO:  rf_raddr = {pair_q, 1'b1};
      default: rf_raddr = reg_q;
    endcase
  end

  assign req_active  = (st == ST_ACC);
  assign access_fire = req_active && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_hi <= '0;
      base_lo <= '0;
      src_q   <= '0;
      xfer_q  <= '0;
    end else begin
      if (st == ST_RHI)  base_hi <= rf_rdata;
      if (st == ST_RLO)  base_lo <= rf_rdata;
      if (st == ST_RSRC) src_q   <= rf_rdata;
      if (access_fire && !dec_q.store) xfer_q <= mem_rdata;
    end
  end

  memxfer_agen u_agen (
    .mode(dec_q.mode), .base_hi(base_hi), .base_lo(base_lo),
    .ext_hi(hi_q), .ext_lo(lo_q), .addr(mem_addr)
  );

  assign pmem_req  = req_active && !dec_q.dspace;
  assign dmem_req  = req_active &&  dec_q.dspace;
  assign mem_we    = req_active &&  dec_q.store;
  assign mem_wdata = src_q;
  assign rf_we     = done && !dec_q.store;
  assign rf_waddr  = reg_q;
  assign rf_wdata  = xfer_q;
  assign illegal   = illegal_q;
endmodule

// File: rtl/memxfer_chk.sv
module memxfer_chk #(
  parameter int CYC_MIN = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        start_accept,
  input logic        pmem_req,
  input logic        dmem_req,
  input logic        mem_ready,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic        rf_we,
  input logic        busy,
  input logic        done,
  input logic        illegal
);
  logic [7:0] age;
  logic       any_req;
  assign any_req = pmem_req || dmem_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age <= '0;
    else if (start_accept) age <= 8'd1;
    else if (busy && age != 8'hFF) age <= age + 8'd1;
  end

  assert_one_space_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pmem_req && dmem_req));

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    any_req && !mem_ready |=> any_req && $stable(mem_addr) && $stable(mem_we) && $stable(pmem_req));

  assert_req_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    any_req && mem_ready |=> !any_req);

  assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !busy && !any_req && !rf_we);

  assert_done_late_enough_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> age >= 8'(CYC_MIN));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  assert_load_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> done && !mem_we);

  assert_busy_ignores_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !done |=> busy);
endmodule

bind memxfer_unit memxfer_chk #(.CYC_MIN(CYC_IND)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_accept(start_accept),
  .pmem_req(pmem_req), .dmem_req(dmem_req), .mem_ready(mem_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .rf_we(rf_we),
  .busy(busy), .done(done), .illegal(illegal)
);

// File: tb/memxfer_unit_tb.sv
module memxfer_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [3:0]  reg_sel = '0, pair_sel = '0;
  logic [7:0]  ext_hi = '0, ext_lo = '0;
  logic [3:0]  rf_raddr, rf_waddr;
  logic [7:0]  rf_rdata, rf_wdata, mem_wdata, mem_rdata;
  logic        rf_we, pmem_req, dmem_req, mem_we, mem_ready, busy, done, illegal;
  logic [15:0] mem_addr;

  int checks = 0, errors = 0;
  int lat_cur = 0, age = 0;
  bit finished = 0;
  logic [7:0] rf [16];
  logic [7:0] pm [int];
  logic [7:0] dm [int];

  always #2 clk = ~clk;

  memxfer_unit u_dut (.*);

  assign rf_rdata  = rf[rf_raddr];
  assign mem_ready = (pmem_req || dmem_req) && (age == lat_cur);
  assign mem_rdata = mem_rd(dmem_req, mem_addr);

  function automatic logic [7:0] mem_rd(input logic ds, input logic [15:0] a);
    if (ds) return dm.exists(int'(a)) ? dm[int'(a)] : (a[7:0] ^ 8'h3C ^ a[15:8]);
    return pm.exists(int'(a)) ? pm[int'(a)] : (a[7:0] + a[15:8] + 8'h11);
  endfunction

  always @(posedge clk) begin
    if (!(pmem_req || dmem_req) || mem_ready) age <= 0; else age <= age + 1;
    if (mem_ready && mem_we) begin
      if (dmem_req) dm[int'(mem_addr)] = mem_wdata;
      else          pm[int'(mem_addr)] = mem_wdata;
    end
    if (rf_we) rf[rf_waddr] <= rf_wdata;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // outputs vector: {busy, pmem_req, dmem_req, mem_we, done, rf_we, illegal}
  function automatic logic [31:0] ovec();
    return {25'd0, busy, pmem_req, dmem_req, mem_we, done, rf_we, illegal};
  endfunction

  task automatic run(input logic [7:0] op, input logic [3:0] r, input logic [3:0] p,
                     input logic [7:0] hi, input logic [7:0] lo, input int lat,
                     input bit extra, input string tag);
    bit ld, st_op, ds;
    int n, dn;
    logic [15:0] base, ea;
    logic [7:0] exp_byte;
    ld    = (op == 8'hC3) || (op == 8'hE7) || (op == 8'hA7);
    st_op = !ld;
    ds    = p[0];
    base  = {rf[{p[3:1], 1'b0}], rf[{p[3:1], 1'b1}]};
    if (op == 8'hC3 || op == 8'hD3) begin n = 10; ea = base; end
    else if (op == 8'hE7 || op == 8'hF7) begin n = 12; ea = base + 16'(signed'(lo)); end
    else if (p[3:1] == 3'd0) begin n = 14; ea = {hi, lo}; end
    else begin n = 14; ea = base + {hi, lo}; end
    dn = (n > 5 + lat) ? n : 5 + lat;
    exp_byte = ld ? mem_rd(ds, ea) : rf[r];
    lat_cur = lat;
    start = 1; opcode = op; reg_sel = r; pair_sel = p; ext_hi = hi; ext_lo = lo;
    @(posedge clk); #1;
    start = 0; opcode = 8'h00; reg_sel = ~r; pair_sel = ~p; ext_hi = ~hi; ext_lo = ~lo;
    for (int k = 1; k <= dn; k++) begin
      bit rq;
      rq = (k >= 4) && (k <= 4 + lat);
      @(negedge clk);
      check({tag, " outputs"}, ovec(),
            {25'd0, 1'b1, rq && !ds, rq && ds, rq && st_op, k == dn, (k == dn) && ld, 1'b0});
      if (rq) check("R7 address held", 32'(mem_addr), 32'(ea));
      if (rq && st_op) check("R6 store data", 32'(mem_wdata), 32'(exp_byte));
      if (k == dn && ld) begin
        check("R6 load data", 32'(rf_wdata), 32'(exp_byte));
        check("R6 load target", 32'(rf_waddr), 32'(r));
      end
      @(posedge clk); #1;
      if (extra && k == 4) begin
        start = 1; opcode = 8'hD3; reg_sel = 4'h2; pair_sel = 4'h3;
      end else begin
        start = 0;
      end
    end
    start = 0;
    @(negedge clk);
    check("R8 idle after done", ovec(), 32'd0);
    @(posedge clk); #1;
  endtask

  task automatic bad_op(input logic [7:0] op);
    start = 1; opcode = op; pair_sel = 4'h4;
    @(posedge clk); #1;
    start = 0;
    @(negedge clk);
    check("R9 illegal pulse", ovec(), 32'd1);
    @(posedge clk); #1;
    @(negedge clk);
    check("R9 illegal cleared", ovec(), 32'd0);
    @(posedge clk); #1;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 8'(i * 37 + 5);
    rf[4] = 8'h12; rf[5] = 8'h34;   // pair 4-5 -> 0x1234
    rf[6] = 8'h40; rf[7] = 8'h10;   // pair 6-7 -> 0x4010
    rf[8] = 8'hF8; rf[9] = 8'h20;   // pair 8-9 -> 0xF820
    @(negedge clk);
    check("R11 reset outputs", ovec(), 32'd0);
    @(posedge clk); @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    check("R11 after reset", ovec(), 32'd0);
    @(posedge clk); #1;
    run(8'hC3, 4'hA, 4'h4, 8'h00, 8'h00, 0, 0, "R1 load prog");
    run(8'hD3, 4'hB, 4'h5, 8'h00, 8'h00, 2, 0, "R1 R5 store data");
    run(8'hC3, 4'hC, 4'h5, 8'h00, 8'h00, 1, 0, "R1 R5 load data readback");
    run(8'hE7, 4'hD, 4'h6, 8'h00, 8'h25, 1, 0, "R2 short positive");
    run(8'hF7, 4'h3, 4'h7, 8'h00, 8'hF0, 0, 0, "R2 short negative");
    run(8'hA7, 4'h2, 4'h8, 8'h10, 8'h01, 3, 0, "R3 long wrap");
    run(8'hB7, 4'h1, 4'h9, 8'h01, 8'h02, 0, 0, "R3 long store");
    run(8'hB7, 4'hE, 4'h1, 8'hAB, 8'hCD, 0, 0, "R4 direct store data");
    run(8'hA7, 4'hF, 4'h1, 8'hAB, 8'hCD, 2, 0, "R4 direct load data");
    run(8'hA7, 4'h0, 4'h0, 8'h77, 8'h66, 0, 0, "R4 R5 direct load prog");
    run(8'hC3, 4'hA, 4'h4, 8'h00, 8'h00, 9, 0, "R8 late ready");
    run(8'hA7, 4'h6, 4'h8, 8'h00, 8'h00, 12, 0, "R8 late ready long");
    run(8'hC3, 4'hB, 4'h6, 8'h00, 8'h00, 0, 1, "R10 start while busy");
    bad_op(8'h55);
    bad_op(8'hC7);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule